// File: doc/BRIEF.md
# Flash Page-Write Controller

This block sits between an 8-bit CPU bus and an on-chip flash array and handles writes to the array. While a mapping bit in its control register is set, CPU data writes stop going to ordinary data memory. Each one instead fills one byte of a page-wide bank of column latches, picked by the low address bits, and sets a loaded flag for that byte. Any number of bytes from one to a full page may be loaded. The upper address bits of the first write after the latches were last cleared choose the flash page.

A programming cycle is unlocked by two control-register writes in a row. The first carries key 5h and the second carries key Ah. The mode field of the second write selects the target space. Once started, the block drives an erase strobe and then a program strobe, each for a fixed number of clocks. Per-byte enables go with both strobes, so only the loaded bytes are erased and rewritten and the rest of the page keeps its contents. A busy bit and a CPU hold request cover the whole cycle. When the cycle ends, the loaded flags clear.

Top module: `flash_page_writer`

## Requirements
- R1: While `ctl_rdata[3]` (map bit, written through `ctl_wdata[2]`) is 1, a `mem_we` write stores `mem_wdata` into the latch at offset `mem_addr[OFF_W-1:0]`, sets bit offset of `arr_byte_en`, and keeps `ram_we` low. While the map bit is 0, `ram_we` follows `mem_we` and no loaded flag changes.
- R2: During a cycle, `arr_byte_en` has exactly the offsets loaded since the last clear. `arr_wdata[8*i+:8]` holds the last byte written to offset i. Bytes that were not loaded are neither erased nor programmed.
- R3: `arr_page` equals `mem_addr[ADDR_W-1:OFF_W]` of the first latch write after the flags were last cleared. Later latch writes with other upper bits do not change it.
- R4: A cycle starts only on a control write with key `ctl_wdata[6:3]`=Ah that directly follows a control write with key 5h. Any other control write in between, or any second key other than Ah, returns the unlock logic to idle.
- R5: `arr_erase` is high for ERASE_CYC clocks, starting the clock after the starting write. `arr_prog` is then high for the next PROG_CYC clocks. The two strobes are never high together.
- R6: `ctl_rdata[0]` (busy) and `cpu_hold` are both high for exactly ERASE_CYC+PROG_CYC clocks per cycle and low otherwise.
- R7: The mode field `ctl_wdata[1:0]` drives `arr_space`: 00 selects user space, 01 the extra row, 10 the fuse bits. With mode 11 the unlock starts nothing and the loaded flags are kept.
- R8: All loaded flags clear when the program phase ends. An unlock with no loaded byte produces no busy and no strobe.
- R9: While busy, control writes (including keys) and latch writes are ignored.
- R10: After reset `ctl_rdata`, `cpu_hold`, `arr_erase`, `arr_prog` and `arr_byte_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | {key[3:0], map, mode[1:0]} |
| ctl_rdata | output | 4 | {map, mode[1:0], busy} |
| mem_we | input | 1 | CPU data write strobe |
| mem_addr | input | ADDR_W | CPU data write address |
| mem_wdata | input | 8 | CPU data write byte |
| ram_we | output | 1 | Write strobe to normal data memory |
| cpu_hold | output | 1 | Idle request to the CPU during a cycle |
| arr_page | output | ADDR_W-OFF_W | Page address to the array |
| arr_space | output | 2 | Target space: 00 user, 01 extra row, 10 fuse |
| arr_erase | output | 1 | Erase strobe |
| arr_prog | output | 1 | Program strobe |
| arr_byte_en | output | PAGE_BYTES | Per-byte loaded flags / enables |
| arr_wdata | output | 8*PAGE_BYTES | Latch contents, byte i at bits 8i+7:8i |

## Verification
The bench builds the block with an 8-byte page, a 10-bit address, a 3-clock erase phase and a 5-clock program phase. The small page means a full page, a single byte, and a load whose offsets wrap past the page end all fit in a few writes. It also makes the highest page address (127) reachable. The short phases let a check that arrives during busy land inside the erase or program window, and the exact strobe lengths can be counted cheaply.

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int PAGE_BYTES = 128,
  parameter int ADDR_W     = 16,
  parameter int ERASE_CYC  = 20,
  parameter int PROG_CYC   = 30,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctl_we,
  input  logic [6:0]              ctl_wdata,
  output logic [3:0]              ctl_rdata,
  input  logic                    mem_we,
  input  logic [ADDR_W-1:0]       mem_addr,
  input  logic [7:0]              mem_wdata,
  output logic                    ram_we,
  output logic                    cpu_hold,
  output logic [PAGE_W-1:0]       arr_page,
  output logic [1:0]              arr_space,
  output logic                    arr_erase,
  output logic                    arr_prog,
  output logic [PAGE_BYTES-1:0]   arr_byte_en,
  output logic [8*PAGE_BYTES-1:0] arr_wdata
);
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_ERASE, S_PROG} state_t;

  state_t                st_q;
  logic [CNT_W-1:0]      tmr_q;
  logic                  map_q, armed_q;
  logic [1:0]            mode_q;
  logic [PAGE_W-1:0]     page_q;
  logic [PAGE_BYTES-1:0] loaded_q;
  logic [7:0]            lat_q [PAGE_BYTES];

  wire       busy   = (st_q != S_IDLE);
  wire [3:0] key    = ctl_wdata[6:3];
  wire [1:0] wmode  = ctl_wdata[1:0];
  wire       ctl_ok = ctl_we & ~busy;
  wire       lat_ok = mem_we & map_q & ~busy;
  wire       start  = ctl_ok & armed_q & (key == 4'hA) & (wmode != 2'b11) & (|loaded_q);
  wire [OFF_W-1:0] off = mem_addr[OFF_W-1:0];

  assign ctl_rdata   = {map_q, mode_q, busy};
  assign ram_we      = mem_we & ~map_q;
  assign cpu_hold    = busy;
  assign arr_page    = page_q;
  assign arr_space   = mode_q;
  assign arr_erase   = (st_q == S_ERASE);
  assign arr_prog    = (st_q == S_PROG);
  assign arr_byte_en = loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      tmr_q    <= '0;
      map_q    <= 1'b0;
      armed_q  <= 1'b0;
      mode_q   <= 2'b00;
      page_q   <= '0;
      loaded_q <= '0;
    end else begin
      if (ctl_ok) begin
        map_q   <= ctl_wdata[2];
        mode_q  <= wmode;
        armed_q <= ~armed_q & (key == 4'h5);
      end
      if (lat_ok) begin
        loaded_q[off] <= 1'b1;
        if (~|loaded_q) page_q <= mem_addr[ADDR_W-1:OFF_W];
      end
      case (st_q)
        S_IDLE: if (start) begin
          st_q  <= S_ERASE;
          tmr_q <= '0;
        end
        S_ERASE: if (tmr_q == CNT_W'(ERASE_CYC - 1)) begin
          st_q  <= S_PROG;
          tmr_q <= '0;
        end else tmr_q <= tmr_q + 1'b1;
        S_PROG: if (tmr_q == CNT_W'(PROG_CYC - 1)) begin
          st_q     <= S_IDLE;
          tmr_q    <= '0;
          loaded_q <= '0;
        end else tmr_q <= tmr_q + 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (lat_ok) lat_q[off] <= mem_wdata;
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_out
    assign arr_wdata[8*i +: 8] = lat_q[i];
  end
endmodule

// File: rtl/flash_page_writer_chk.sv
module flash_page_writer_chk #(
  parameter int PAGE_BYTES = 128
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ctl_we,
  input logic                  mem_we,
  input logic                  cpu_hold,
  input logic                  arr_erase,
  input logic                  arr_prog,
  input logic [PAGE_BYTES-1:0] arr_byte_en
);
  assert_phase_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_erase && arr_prog));

  assert_prog_follows_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_erase) |-> arr_prog);

  assert_hold_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_hold) |-> $past(ctl_we));

  assert_erase_has_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase |-> (arr_byte_en != '0));

  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_prog) |-> (arr_byte_en == '0));

  assert_latch_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && mem_we && !arr_prog) |=> $stable(arr_byte_en));
endmodule

bind flash_page_writer flash_page_writer_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .mem_we(mem_we),
  .cpu_hold(cpu_hold), .arr_erase(arr_erase), .arr_prog(arr_prog),
  .arr_byte_en(arr_byte_en)
);

// File: tb/sim_flash_page_writer.sv
module sim_flash_page_writer;
  localparam int PB = 8, AW = 10, EC = 3, PC = 5;
  localparam int OW = 3, PW = AW - OW, MSZ = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, mem_we = 0;
  logic [6:0] ctl_wdata = '0;
  logic [3:0] ctl_rdata;
  logic [AW-1:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0;
  logic ram_we, cpu_hold, arr_erase, arr_prog;
  logic [PW-1:0] arr_page;
  logic [1:0] arr_space;
  logic [PB-1:0] arr_byte_en;
  logic [8*PB-1:0] arr_wdata;

  always #2.5 clk = ~clk;

  flash_page_writer #(.PAGE_BYTES(PB), .ADDR_W(AW), .ERASE_CYC(EC), .PROG_CYC(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ram_we(ram_we),
    .cpu_hold(cpu_hold), .arr_page(arr_page), .arr_space(arr_space), .arr_erase(arr_erase),
    .arr_prog(arr_prog), .arr_byte_en(arr_byte_en), .arr_wdata(arr_wdata));

  // behavioural flash array and monitors
  logic [7:0] flash [3][MSZ];
  int ecnt = 0, pcnt = 0, hcnt = 0, ovl = 0, mism = 0;
  logic [1:0] sp_seen;
  logic [PW-1:0] pg_seen;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 3; s++)
        for (int a = 0; a < MSZ; a++) flash[s][a] <= 8'(a) ^ 8'h3C ^ 8'(s);
    end else begin
      if (arr_erase) begin
        ecnt <= ecnt + 1;
        for (int i = 0; i < PB; i++)
          if (arr_byte_en[i]) flash[arr_space][int'(arr_page)*PB+i] <= 8'hFF;
      end
      if (arr_prog) begin
        pcnt <= pcnt + 1;
        sp_seen <= arr_space;
        pg_seen <= arr_page;
        for (int i = 0; i < PB; i++)
          if (arr_byte_en[i])
            flash[arr_space][int'(arr_page)*PB+i] <= flash[arr_space][int'(arr_page)*PB+i] & arr_wdata[8*i +: 8];
      end
      if (cpu_hold) hcnt <= hcnt + 1;
      if (arr_erase && arr_prog) ovl <= ovl + 1;
      if (ctl_rdata[0] != cpu_hold) mism <= mism + 1;
    end
  end

  logic [7:0] expf [3][MSZ];
  int errs = 0, total = 0;
  int e0, p0, h0, o0, m0;
  logic ram_seen;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] cv(input logic [3:0] k, input logic m, input logic [1:0] md);
    return {k, m, md};
  endfunction

  task automatic ctl_wr(input logic [6:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic mem_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); mem_we = 1; mem_addr = a; mem_wdata = d;
    #1 ram_seen = ram_we;
    @(negedge clk); mem_we = 0;
  endtask

  task automatic snap();
    e0 = ecnt; p0 = pcnt; h0 = hcnt; o0 = ovl; m0 = mism;
  endtask

  task automatic wait_idle();
    while (cpu_hold) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic unlock(input logic [1:0] md);
    snap();
    ctl_wr(cv(4'h5, 1'b1, md));
    ctl_wr(cv(4'hA, 1'b1, md));
    wait_idle();
  endtask

  task automatic load(input logic [PW-1:0] pg, input logic [OW-1:0] o, input logic [1:0] md, input logic [7:0] d);
    mem_wr({pg, o}, d);
    expf[md][int'(pg)*PB + int'(o)] = d;
  endtask

  function automatic bit page_ok(input int sp, input int pg);
    for (int i = 0; i < PB; i++)
      if (flash[sp][pg*PB+i] !== expf[sp][pg*PB+i]) return 0;
    return 1;
  endfunction

  // {mode[1:0], seed[7:0], count[3:0], first_offset[2:0], page[6:0]}
  localparam logic [23:0] VEC [5] = '{
    {2'd0, 8'h11, 4'd8, 3'd0, 7'd5},
    {2'd0, 8'hA5, 4'd1, 3'd3, 7'd5},
    {2'd1, 8'h40, 4'd4, 3'd6, 7'd2},
    {2'd2, 8'h77, 4'd3, 3'd1, 7'd0},
    {2'd0, 8'hC3, 4'd2, 3'd5, 7'd127}
  };

  initial begin
    repeat (20000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < MSZ; a++) expf[s][a] = 8'(a) ^ 8'h3C ^ 8'(s);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(ctl_rdata == 4'h0, "R10 ctl_rdata", ctl_rdata, 0);
    chk(!cpu_hold && !arr_erase && !arr_prog, "R10 strobes", {cpu_hold, arr_erase, arr_prog}, 0);
    chk(arr_byte_en == '0, "R10 byte_en", arr_byte_en, 0);

    // R1 routing with map clear and set
    ctl_wr(cv(4'h0, 1'b0, 2'd0));
    mem_wr(10'h123, 8'h9E);
    chk(ram_seen == 1'b1, "R1 ram_we map clear", ram_seen, 1);
    chk(arr_byte_en == '0, "R1 no latch map clear", arr_byte_en, 0);
    ctl_wr(cv(4'h0, 1'b1, 2'd0));
    load(7'd9, 3'd2, 2'd0, 8'h5A);
    chk(ram_seen == 1'b0, "R1 ram_we map set", ram_seen, 0);
    chk(arr_byte_en == 8'h04, "R1 flag set", arr_byte_en, 8'h04);
    // R3 page from first write only
    mem_wr({7'd10, 3'd6}, 8'h6B);
    expf[0][9*PB+6] = 8'h6B;
    unlock(2'd0);
    chk(pg_seen == 7'd9, "R3 page of first write", pg_seen, 9);
    chk(page_ok(0, 9) && page_ok(0, 10), "R3 page contents", flash[0][9*PB+6], 8'h6B);

    // table walk: R2 R5 R6 R7 R8
    for (int v = 0; v < 5; v++) begin
      logic [6:0] pg; logic [2:0] of; logic [3:0] cn; logic [7:0] sd; logic [1:0] md;
      {md, sd, cn, of, pg} = VEC[v];
      ctl_wr(cv(4'h0, 1'b1, md));
      for (int k = 0; k < int'(cn); k++)
        load(pg, of + 3'(k), md, sd + 8'(k * 19));
      unlock(md);
      chk(ecnt - e0 == EC, "R5 erase length", ecnt - e0, EC);
      chk(pcnt - p0 == PC, "R5 program length", pcnt - p0, PC);
      chk(ovl == o0, "R5 strobe overlap", ovl - o0, 0);
      chk(hcnt - h0 == EC + PC, "R6 hold length", hcnt - h0, EC + PC);
      chk(mism == m0, "R6 busy equals hold", mism - m0, 0);
      chk(sp_seen == md, "R7 space", sp_seen, md);
      chk(pg_seen == pg, "R3 page", pg_seen, pg);
      chk(arr_byte_en == '0, "R8 flags cleared", arr_byte_en, 0);
      chk(page_ok(md, pg), "R2 page contents", v, v);
    end

    // R4 broken and wrong key sequences
    load(7'd20, 3'd0, 2'd0, 8'h01);
    snap();
    ctl_wr(cv(4'h5, 1'b1, 2'd0)); ctl_wr(cv(4'h0, 1'b1, 2'd0)); ctl_wr(cv(4'hA, 1'b1, 2'd0));
    repeat (3) @(negedge clk);
    chk(hcnt == h0, "R4 interrupted sequence", hcnt - h0, 0);
    ctl_wr(cv(4'h5, 1'b1, 2'd0)); ctl_wr(cv(4'h3, 1'b1, 2'd0)); ctl_wr(cv(4'hA, 1'b1, 2'd0));
    repeat (3) @(negedge clk);
    chk(hcnt == h0, "R4 wrong second key", hcnt - h0, 0);
    ctl_wr(cv(4'h5, 1'b1, 2'd0)); ctl_wr(cv(4'h5, 1'b1, 2'd0)); ctl_wr(cv(4'hA, 1'b1, 2'd0));
    repeat (3) @(negedge clk);
    chk(hcnt == h0, "R4 repeated first key", hcnt - h0, 0);
    unlock(2'd0);
    chk(hcnt - h0 == EC + PC && page_ok(0, 20), "R4 good sequence", hcnt - h0, EC + PC);

    // R7 mode 11 does nothing and keeps flags
    load(7'd30, 3'd4, 2'd1, 8'h44);
    unlock(2'd3);
    chk(hcnt == h0, "R7 mode 11 no cycle", hcnt - h0, 0);
    chk(arr_byte_en == 8'h10, "R7 mode 11 keeps flags", arr_byte_en, 8'h10);
    unlock(2'd1);
    chk(page_ok(1, 30), "R7 extra row write", flash[1][30*PB+4], 8'h44);

    // R8 empty unlock
    unlock(2'd0);
    chk(hcnt == h0 && ecnt == e0, "R8 empty unlock", hcnt - h0, 0);

    // R9 writes ignored while busy
    load(7'd40, 3'd0, 2'd0, 8'h12);
    snap();
    ctl_wr(cv(4'h5, 1'b1, 2'd0));
    ctl_wr(cv(4'hA, 1'b1, 2'd0));
    mem_wr({7'd40, 3'd7}, 8'h99);
    ctl_wr(cv(4'h5, 1'b0, 2'd2));
    wait_idle();
    chk(page_ok(0, 40), "R9 busy latch write ignored", flash[0][40*PB+7], expf[0][40*PB+7]);
    chk(ctl_rdata[3:1] == 3'b100, "R9 busy control write ignored", ctl_rdata[3:1], 3'b100);
    load(7'd41, 3'd0, 2'd0, 8'h21);
    snap();
    ctl_wr(cv(4'hA, 1'b1, 2'd0));
    repeat (3) @(negedge clk);
    chk(hcnt == h0, "R9 busy key not armed", hcnt - h0, 0);
    unlock(2'd0);
    chk(page_ok(0, 41), "R9 later cycle", flash[0][41*PB], 8'h21);

    $display("  Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule